// File: doc/BRIEF.md
# Multi-Tap Carrier-Wipe Correlator Bank

This block is the signal-processing core of one tracking channel of a satellite-navigation receiver. Each accepted 4-bit intermediate-frequency sample is multiplied by a sine and a cosine replica. The replicas come from a 32-entry phase table that is addressed by the top bits of a 32-bit carrier oscillator. The two products are then correlated against a bank of delayed copies of the local spreading code. A spacing oscillator advances the delay line. It is programmed to run a chosen multiple of the code rate, which sets the tap spacing to a fraction of a chip.

Each tap keeps an in-phase and a quadrature running sum. At every code-epoch boundary the sums of all taps are captured on a parallel output bus, and the bank freezes. It takes no further samples until the host releases it. This gives the host time to read the results and update the oscillator words. Running counts of whole carrier cycles, code periods and epochs are provided, together with the fractional carrier phase.

Top module: `corr_bank`

## Requirements
- R1: After reset, `smp_ready` is 1, `dump_valid` is 0, and every counter, the carrier phase and both dump buses are 0.
- R2: A sample is accepted when `smp_valid` is 1 and the bank is not stalled. The table index is carrier phase bits [31:27]. The table uses magnitudes M = {1,2,4,5,6,7,7,7}. For index p with quadrant q = p[4:3] and offset i = p[2:0], the value is +M[i], +M[7-i], -M[i] or -M[7-i] for q = 0, 1, 2 and 3. The sine value is table(p) and the cosine value is table(p+8 mod 32). The sample is read as 4-bit two's complement. The I term is sample×sine and the Q term is sample×cosine, and both are negated for a tap whose chip is 1.
- R3: Each accepted sample adds the carrier frequency word to the 32-bit carrier phase, which is readable on `car_frac`. Each wrap past 2^32 adds one to `car_cycles`.
- R4: Each accepted sample also adds the spacing word to a 32-bit spacing phase. On a wrap, `code_chip` enters tap 0 and every tap k takes the old value of tap k-1. All taps are 0 after reset.
- R5: An accepted sample with `code_epoch` high marks a code-period start. On every EPOCH_PERIODS-th such start, the sums from before that sample are placed on `dump_i`/`dump_q` (tap k at bits k·32 and up). In the same cycle the new sums start with that sample's terms. `dump_valid` is high for exactly the following cycle.
- R6: In the cycle after a dump, `smp_ready` is 0, and samples are neither accumulated nor used to step the oscillators. A `host_resume` pulse while stalled makes `smp_ready` 1 from the next cycle on.
- R7: The dump buses hold their values until the next dump.
- R8: `period_cnt` counts accepted code-period starts and `epoch_cnt` counts dumps.
- R9: `cfg_load` sets the carrier word, the carrier phase and the spacing word, and clears the spacing phase. `car_cycles` is unchanged.
- R10: `host_resume` while not stalled has no effect.
- R11: A sample with `smp_valid` low changes no sum, phase, tap or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the oscillator programming words |
| cfg_car_fcw | input | 32 | Carrier frequency word |
| cfg_car_phase | input | 32 | Carrier start phase |
| cfg_spc_fcw | input | 32 | Spacing frequency word |
| smp_valid | input | 1 | Sample present |
| smp_data | input | 4 | Signed IF sample |
| code_chip | input | 1 | Current local code chip (1 means −1) |
| code_epoch | input | 1 | This sample begins a code period |
| smp_ready | output | 1 | Bank accepts samples |
| host_resume | input | 1 | Release the stall after a dump |
| dump_valid | output | 1 | New dump on the buses |
| dump_i | output | NTAPS·32 | In-phase sums, one 32-bit field per tap |
| dump_q | output | NTAPS·32 | Quadrature sums, one 32-bit field per tap |
| car_cycles | output | 32 | Whole carrier cycles |
| car_frac | output | 32 | Fractional carrier phase |
| period_cnt | output | 32 | Code periods seen |
| epoch_cnt | output | 32 | Dumps issued |

## Verification
A wrong table entry or a wrong carrier index corrupts every tap's sums. This becomes visible on the dump buses at the next epoch. A tap line that shifts at the wrong time or in the wrong direction shows up as different sums for the affected taps at that same dump. A stall flag that is wrong changes `smp_ready` one cycle after the dump. Samples taken during a stall change `car_frac` on the very next cycle. A phase or counter error appears on `car_frac`, `car_cycles`, `period_cnt` or `epoch_cnt` in the cycle after the sample that caused it. The bench compares all of these against its model on every clock.

// File: rtl/corr_bank_pkg.sv
package corr_bank_pkg;

   localparam int CAR_IDX_W = 5;
   localparam int LUT_W     = 4;

   // quarter-wave replica: quadrant from the two top index bits
   function automatic logic signed [LUT_W-1:0] wave_lut(input logic [CAR_IDX_W-1:0] idx);
      logic [2:0]             off;
      logic signed [LUT_W-1:0] mag;
      off = idx[3] ? ~idx[2:0] : idx[2:0];
      case (off)
         3'd0:    mag = 4'sd1;
         3'd1:    mag = 4'sd2;
         3'd2:    mag = 4'sd4;
         3'd3:    mag = 4'sd5;
         3'd4:    mag = 4'sd6;
         default: mag = 4'sd7;
      endcase
      return idx[4] ? -mag : mag;
   endfunction

endpackage

// File: rtl/corr_carrier.sv
module corr_carrier #(
   parameter int PH_W  = 32,
   parameter int IDX_W = 5,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [PH_W-1:0]  load_fcw,
   input  logic [PH_W-1:0]  load_phase,
   output logic [IDX_W-1:0] idx,
   output logic [PH_W-1:0]  phase,
   output logic [CNT_W-1:0] cycles
);

   if (IDX_W > PH_W) begin : g_bad_idx
      $error("corr_carrier: index wider than phase");
   end

   logic [PH_W-1:0] fcw;
   logic [PH_W:0]   sum;

   assign sum = {1'b0, phase} + {1'b0, fcw};
   assign idx = phase[PH_W-1 -: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcw    <= '0;
         phase  <= '0;
         cycles <= '0;
      end else if (load) begin
         fcw   <= load_fcw;
         phase <= load_phase;
      end else if (step) begin
         phase <= sum[PH_W-1:0];
         if (sum[PH_W]) cycles <= cycles + 1'b1;
      end
   end

   // R3 / R9: whole-cycle count only moves on a stepping, non-loading cycle
   assert_cycles_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step || load) |=> $stable(cycles));

   assert_cycles_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cycles == $past(cycles) || cycles == $past(cycles) + 1'b1));

endmodule

// File: rtl/corr_tapline.sv
module corr_tapline #(
   parameter int NTAPS = 5,
   parameter int PH_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [PH_W-1:0]  load_fcw,
   input  logic             chip,
   output logic [NTAPS-1:0] taps
);

   if (NTAPS < 1) begin : g_bad_taps
      $error("corr_tapline: need at least one tap");
   end

   logic [PH_W-1:0] fcw;
   logic [PH_W-1:0] phase;
   logic [PH_W:0]   sum;
   logic            tick;

   assign sum  = {1'b0, phase} + {1'b0, fcw};
   assign tick = step && !load && sum[PH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcw   <= '0;
         phase <= '0;
      end else if (load) begin
         fcw   <= load_fcw;
         phase <= '0;
      end else if (step) begin
         phase <= sum[PH_W-1:0];
      end
   end

   if (NTAPS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    taps <= '0;
         else if (tick) taps <= chip;
      end
   end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    taps <= '0;
         else if (tick) taps <= {taps[NTAPS-2:0], chip};
      end
   end

   // R4 / R11: the delay line holds unless a sample is taken
   assert_taps_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(taps));

endmodule

// File: rtl/corr_tap_acc.sv
module corr_tap_acc #(
   parameter int ACC_W  = 32,
   parameter int PROD_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic                     restart,
   input  logic                     chip,
   input  logic signed [PROD_W-1:0] prod_i,
   input  logic signed [PROD_W-1:0] prod_q,
   output logic signed [ACC_W-1:0]  acc_i,
   output logic signed [ACC_W-1:0]  acc_q
);

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("corr_tap_acc: accumulator narrower than product");
   end

   logic signed [ACC_W-1:0] ext_i, ext_q, term_i, term_q;

   assign ext_i  = ACC_W'(prod_i);
   assign ext_q  = ACC_W'(prod_q);
   assign term_i = chip ? -ext_i : ext_i;
   assign term_q = chip ? -ext_q : ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_i <= '0;
         acc_q <= '0;
      end else if (step) begin
         acc_i <= restart ? term_i : acc_i + term_i;
         acc_q <= restart ? term_q : acc_q + term_q;
      end
   end

   // R11: no sample, no change
   assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(acc_i) && $stable(acc_q)));

endmodule

// File: rtl/corr_bank.sv
module corr_bank #(
   parameter int NTAPS         = 5,
   parameter int SMP_W         = 4,
   parameter int NCO_W         = 32,
   parameter int ACC_W         = 32,
   parameter int CNT_W         = 32,
   parameter int EPOCH_PERIODS = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_load,
   input  logic [NCO_W-1:0]       cfg_car_fcw,
   input  logic [NCO_W-1:0]       cfg_car_phase,
   input  logic [NCO_W-1:0]       cfg_spc_fcw,
   input  logic                   smp_valid,
   input  logic [SMP_W-1:0]       smp_data,
   input  logic                   code_chip,
   input  logic                   code_epoch,
   output logic                   smp_ready,
   input  logic                   host_resume,
   output logic                   dump_valid,
   output logic [NTAPS*ACC_W-1:0] dump_i,
   output logic [NTAPS*ACC_W-1:0] dump_q,
   output logic [CNT_W-1:0]       car_cycles,
   output logic [NCO_W-1:0]       car_frac,
   output logic [CNT_W-1:0]       period_cnt,
   output logic [CNT_W-1:0]       epoch_cnt
);
   import corr_bank_pkg::*;

   localparam int IDX_W  = CAR_IDX_W;
   localparam int PROD_W = SMP_W + LUT_W;
   localparam int PER_W  = (EPOCH_PERIODS > 1) ? $clog2(EPOCH_PERIODS) : 1;
   localparam logic [PER_W-1:0] PER_LAST = PER_W'(EPOCH_PERIODS - 1);

   if (EPOCH_PERIODS < 1) begin : g_bad_epoch
      $error("corr_bank: EPOCH_PERIODS must be positive");
   end
   if (NCO_W < IDX_W) begin : g_bad_nco
      $error("corr_bank: oscillator narrower than table index");
   end

   logic                    stalled;
   logic                    accept;
   logic                    dump_now;
   logic [PER_W-1:0]        per_in;
   logic [IDX_W-1:0]        car_idx;
   logic signed [LUT_W-1:0] rep_sin, rep_cos;
   logic signed [PROD_W-1:0] smp_ext, sin_ext, cos_ext, prod_i, prod_q;
   logic [NTAPS-1:0]        taps;

   assign smp_ready = !stalled;
   assign accept    = smp_valid && !stalled;
   assign dump_now  = accept && code_epoch && (per_in == PER_LAST);

   corr_carrier #(.PH_W(NCO_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_car (
      .clk(clk), .rst_n(rst_n), .step(accept), .load(cfg_load),
      .load_fcw(cfg_car_fcw), .load_phase(cfg_car_phase),
      .idx(car_idx), .phase(car_frac), .cycles(car_cycles));

   corr_tapline #(.NTAPS(NTAPS), .PH_W(NCO_W)) u_line (
      .clk(clk), .rst_n(rst_n), .step(accept), .load(cfg_load),
      .load_fcw(cfg_spc_fcw), .chip(code_chip), .taps(taps));

   assign rep_sin = wave_lut(car_idx);
   assign rep_cos = wave_lut(car_idx + IDX_W'(8));
   assign smp_ext = PROD_W'($signed(smp_data));
   assign sin_ext = PROD_W'(rep_sin);
   assign cos_ext = PROD_W'(rep_cos);
   assign prod_i  = smp_ext * sin_ext;
   assign prod_q  = smp_ext * cos_ext;

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      logic signed [ACC_W-1:0] sum_i, sum_q, snap_i, snap_q;

      corr_tap_acc #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .step(accept), .restart(dump_now),
         .chip(taps[k]), .prod_i(prod_i), .prod_q(prod_q),
         .acc_i(sum_i), .acc_q(sum_q));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            snap_i <= '0;
            snap_q <= '0;
         end else if (dump_now) begin
            snap_i <= sum_i;
            snap_q <= sum_q;
         end
      end

      assign dump_i[k*ACC_W +: ACC_W] = snap_i;
      assign dump_q[k*ACC_W +: ACC_W] = snap_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stalled    <= 1'b0;
         dump_valid <= 1'b0;
         per_in     <= '0;
         period_cnt <= '0;
         epoch_cnt  <= '0;
      end else begin
         dump_valid <= dump_now;
         if (dump_now)         stalled <= 1'b1;
         else if (host_resume) stalled <= 1'b0;
         if (accept && code_epoch) begin
            period_cnt <= period_cnt + 1'b1;
            per_in     <= (per_in == PER_LAST) ? '0 : per_in + 1'b1;
         end
         if (dump_now) epoch_cnt <= epoch_cnt + 1'b1;
      end
   end

   // R6: a dump is always accompanied by the stall
   assert_dump_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dump_valid |-> !smp_ready);

   // R6: stall persists until the host releases it
   assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_ready && !host_resume) |=> !smp_ready);

   // R5: dump indication lasts one cycle
   assert_dump_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dump_valid |=> !dump_valid);

   // R8: epoch count advances exactly with a dump
   assert_epoch_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dump_valid |-> (epoch_cnt == $past(epoch_cnt) + 1'b1));

   // R7: dump buses hold between dumps
   assert_dump_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dump_valid |-> ($stable(dump_i) && $stable(dump_q)));

endmodule

// File: tb/corr_bank_tb.sv
`timescale 1ns/1ps
module corr_bank_tb;
   localparam int NT = 4;
   localparam int EP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [31:0] cfg_car_fcw = '0, cfg_car_phase = '0, cfg_spc_fcw = '0;
   logic smp_valid = 1'b0;
   logic [3:0] smp_data = '0;
   logic code_chip = 1'b0, code_epoch = 1'b0, host_resume = 1'b0;
   logic smp_ready, dump_valid;
   logic [NT*32-1:0] dump_i, dump_q;
   logic [31:0] car_cycles, car_frac, period_cnt, epoch_cnt;

   always #2.5 clk = ~clk;

   corr_bank #(.NTAPS(NT), .EPOCH_PERIODS(EP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_car_fcw(cfg_car_fcw),
      .cfg_car_phase(cfg_car_phase), .cfg_spc_fcw(cfg_spc_fcw),
      .smp_valid(smp_valid), .smp_data(smp_data), .code_chip(code_chip),
      .code_epoch(code_epoch), .smp_ready(smp_ready), .host_resume(host_resume),
      .dump_valid(dump_valid), .dump_i(dump_i), .dump_q(dump_q),
      .car_cycles(car_cycles), .car_frac(car_frac), .period_cnt(period_cnt),
      .epoch_cnt(epoch_cnt));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   int unsigned m_ph, m_fcw, m_cyc, m_sph, m_sfcw, m_per, m_epo;
   int m_per_in;
   bit m_stall, m_dv;
   bit m_taps[NT];
   int m_acc_i[NT], m_acc_q[NT], m_dmp_i[NT], m_dmp_q[NT];
   int mags[8] = '{1, 2, 4, 5, 6, 7, 7, 7};

   function automatic int table_val(int p);
      int q = p / 8;
      int i = p % 8;
      case (q)
         0: return mags[i];
         1: return mags[7 - i];
         2: return -mags[i];
         default: return -mags[7 - i];
      endcase
   endfunction

   task automatic model_reset();
      m_ph = 0; m_fcw = 0; m_cyc = 0; m_sph = 0; m_sfcw = 0;
      m_per = 0; m_epo = 0; m_per_in = 0; m_stall = 0; m_dv = 0;
      for (int k = 0; k < NT; k++) begin
         m_taps[k] = 0; m_acc_i[k] = 0; m_acc_q[k] = 0;
         m_dmp_i[k] = 0; m_dmp_q[k] = 0;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit take, fire;
         take = smp_valid && !m_stall;
         fire = 0;
         if (take) begin
            int p, s, si, co, ti, tq;
            p  = int'(m_ph >> 27);
            si = table_val(p);
            co = table_val((p + 8) % 32);
            s  = (smp_data >= 8) ? int'(smp_data) - 16 : int'(smp_data);
            fire = code_epoch && (m_per_in == EP - 1);
            for (int k = 0; k < NT; k++) begin
               ti = m_taps[k] ? -(s * si) : s * si;
               tq = m_taps[k] ? -(s * co) : s * co;
               if (fire) begin
                  m_dmp_i[k] = m_acc_i[k]; m_dmp_q[k] = m_acc_q[k];
                  m_acc_i[k] = ti; m_acc_q[k] = tq;
               end else begin
                  m_acc_i[k] += ti; m_acc_q[k] += tq;
               end
            end
            if (code_epoch) begin
               m_per++;
               m_per_in = (m_per_in == EP - 1) ? 0 : m_per_in + 1;
            end
            if (fire) m_epo++;
         end
         if (cfg_load) begin
            m_fcw = cfg_car_fcw; m_ph = cfg_car_phase; m_sfcw = cfg_spc_fcw; m_sph = 0;
         end else if (take) begin
            longint unsigned a, b;
            a = longint'(m_ph) + longint'(m_fcw);
            if (a >= 64'h1_0000_0000) m_cyc++;
            m_ph = int'(a[31:0]);
            b = longint'(m_sph) + longint'(m_sfcw);
            if (b >= 64'h1_0000_0000) begin
               for (int k = NT - 1; k > 0; k--) m_taps[k] = m_taps[k - 1];
               m_taps[0] = code_chip;
            end
            m_sph = int'(b[31:0]);
         end
         m_dv = fire;
         if (fire) m_stall = 1;
         else if (host_resume) m_stall = 0;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R6 R10 smp_ready", longint'(smp_ready), longint'(!m_stall));
      chk("R5 dump_valid", longint'(dump_valid), longint'(m_dv));
      chk("R3 R11 car_cycles", longint'(car_cycles), longint'(m_cyc));
      chk("R3 R9 R11 car_frac", longint'(car_frac), longint'(m_ph));
      chk("R8 period_cnt", longint'(period_cnt), longint'(m_per));
      chk("R8 epoch_cnt", longint'(epoch_cnt), longint'(m_epo));
      for (int k = 0; k < NT; k++) begin
         chk("R2 R4 R5 R7 dump_i", longint'($signed(dump_i[k*32 +: 32])), longint'(m_dmp_i[k]));
         chk("R2 R4 R5 R7 dump_q", longint'($signed(dump_q[k*32 +: 32])), longint'(m_dmp_q[k]));
      end
   endtask

   task automatic scenario(input logic [31:0] fcw, input logic [31:0] ph,
                           input logic [31:0] sfcw, input int n, input int gap);
      cfg_load = 1; cfg_car_fcw = fcw; cfg_car_phase = ph; cfg_spc_fcw = sfcw;
      smp_valid = 0; code_epoch = 0; host_resume = 0;
      @(negedge clk); compare_all();
      cfg_load = 0;
      for (int c = 0; c < n; c++) begin
         smp_valid   = ($urandom % 8) != 0;
         smp_data    = 4'($urandom);
         code_chip   = 1'($urandom);
         code_epoch  = ($urandom % gap) == 0;
         host_resume = m_stall ? (($urandom % 4) == 0) : (($urandom % 16) == 0);
         @(negedge clk); compare_all();
      end
      smp_valid = 0; code_epoch = 0; host_resume = 0;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: state while and right after reset
      chk("R1 ready", longint'(smp_ready), 1);
      chk("R1 dump_valid", longint'(dump_valid), 0);
      chk("R1 counters", longint'(car_cycles | period_cnt | epoch_cnt), 0);
      chk("R1 phase", longint'(car_frac), 0);
      chk("R1 dump bus", longint'(|{dump_i, dump_q}), 0);
      rst_n = 1;
      @(negedge clk); compare_all();
      scenario(32'h0800_0000, 32'h0,        32'h4000_0000, 3000, 20);
      scenario(32'h9E37_79B9, 32'h1234_5678, 32'hFFFF_FFFF, 3000, 13);
      scenario(32'h0,         32'h4000_0000, 32'h0,         2000, 9);
      scenario(32'hF800_0000, 32'hC000_0000, 32'h2AAA_AAAB, 3000, 30);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule